// File: doc/BRIEF.md
# Busy-Aware Dual-Port RAM Requester

This block sits in front of one port of an asynchronous-style dual-port RAM whose port reports a BUSY indication when it loses arbitration for a location. A host hands it one access at a time over a valid/ready request channel: address, write data, a per-byte write mask and a read/write flag. The block drives the RAM port with an enable, an output enable and per-byte write strobes. It then reports a one-cycle response carrying read data or a write acknowledgement.

BUSY is treated as "not ready". While it is high during a strobe cycle, the access does not count as done. Address, data and strobes stay frozen. Once BUSY drops, the same strobe is driven for one more cycle, and only a busy-free strobe cycle completes the access. If BUSY comes back during that extra cycle, the block returns to waiting. When the block drives a device whose BUSY input is relayed from another device, writes hold address and enable for a programmable number of settle cycles before any write strobe is raised. A timeout gives up on an access that stays busy too long.

Back-pressure rules: `req_ready` is high only while the block is idle, and a request transfers on a cycle where `req_valid` and `req_ready` are both high. The host must keep its request fields stable until that cycle. The response has no ready: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `busy_port_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no access is in progress: from reset, and from the cycle after a response or a timeout. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: After a request is accepted, `mem_ce` rises with the captured address and stays high through the access, with no strobe yet. The address-only phase lasts 1 cycle for reads and for every access when `SLAVE_MODE` is 0. It lasts `SETTLE_CYC` cycles for writes when `SLAVE_MODE` is 1.
- R3: In a strobe cycle, a read drives `mem_oe`=1 and `mem_we`=0. A write drives `mem_oe`=0 and `mem_we` equal to the captured byte mask, where bit i enables byte i (`mem_wdata[8i+7:8i]`). `mem_addr` and `mem_wdata` carry the accepted request.
- R4: A strobe cycle in which `mem_busy` is 1 does not complete the access. `mem_ce`, `mem_oe`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged for as long as `mem_busy` remains 1, and no response is issued.
- R5: In the first cycle in which `mem_busy` is 0 after a busy strobe cycle, the strobe is still driven. The strobe cycle that follows it repeats the operation. If `mem_busy` is 1 in that repeated cycle, the block waits again as in R4.
- R6: An access completes on a strobe cycle with `mem_busy` 0. In the next cycle `rsp_valid` is 1 for exactly one cycle and `mem_ce` is 0. `rsp_is_write` equals the request's write flag. For reads, `rsp_rdata` holds `mem_rdata` as sampled in that completing cycle.
- R7: If `mem_busy` stays 1 for `TIMEOUT_CYC` consecutive waiting cycles, the access is abandoned. `err_timeout` is then 1 for one cycle while the block is idle with `mem_ce` 0, and no `rsp_valid` is issued for that request.
- R8: While `rst_n` is 0, `req_ready` is 1 and `rsp_valid`, `err_timeout`, `mem_ce`, `mem_oe` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Request write data |
| req_be | input | DW/8 | Write byte mask, bit i for byte i |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_is_write | output | 1 | Completed access was a write |
| rsp_rdata | output | DW | Read data of the completed read |
| err_timeout | output | 1 | One-cycle pulse when an access is abandoned |
| mem_ce | output | 1 | RAM port enable, active high |
| mem_oe | output | 1 | RAM port output enable, active high |
| mem_we | output | DW/8 | RAM port byte write strobes, active high |
| mem_addr | output | AW | RAM port address |
| mem_wdata | output | DW | RAM port write data |
| mem_rdata | input | DW | RAM port read data |
| mem_busy | input | 1 | RAM port busy, active high |

## Verification
The hardest case to reach is a BUSY that drops and then returns right in the repeated strobe cycle. Only that case exercises the path from the repeated cycle back into waiting. Close behind it is a BUSY lasting exactly one cycle less than the timeout. The bench drives BUSY from a per-transaction bit pattern indexed by cycles since acceptance, so these edges land on exact cycles. While BUSY is high, the RAM model returns a poison word, so data captured too early shows up as a wrong read.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACCESS, S_WAIT, S_EXTEND, S_DONE
  } bpa_state_e;
endpackage

// File: rtl/bpa_cycle_cnt.sv
module bpa_cycle_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bpa_req_hold.sv
module bpa_req_hold #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [BW-1:0] in_be,
  input  logic          in_wr,
  input  logic          cap,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_wdata,
  output logic [BW-1:0] h_be,
  output logic          h_wr,
  output logic [DW-1:0] h_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr  <= '0;
      h_wdata <= '0;
      h_be    <= '0;
      h_wr    <= 1'b0;
    end else if (load) begin
      h_addr  <= in_addr;
      h_wdata <= in_wdata;
      h_be    <= in_be;
      h_wr    <= in_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   h_rdata <= '0;
    else if (cap) h_rdata <= mem_rdata;
  end
endmodule

// File: rtl/bpa_ctrl.sv
module bpa_ctrl
  import bpa_pkg::*;
#(
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 16,
  parameter bit SLAVE_MODE  = 1'b1,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          h_wr,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  output bpa_state_e    state,
  output logic          load,
  output logic          cap,
  output logic          clr,
  output logic          inc,
  output logic          err_pulse
);
  localparam logic [CW-1:0] LAST_TO = CW'(TIMEOUT_CYC - 1);

  bpa_state_e nxt;
  logic       tmo;
  logic       setup_last;

  generate
    if (SLAVE_MODE) begin : g_settle
      localparam logic [CW-1:0] LAST_SET = CW'(SETTLE_CYC - 1);
      assign setup_last = !h_wr || (cnt == LAST_SET);
    end else begin : g_nosettle
      assign setup_last = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt  = state;
    load = 1'b0;
    cap  = 1'b0;
    clr  = 1'b0;
    inc  = 1'b0;
    tmo  = 1'b0;
    unique case (state)
      S_IDLE: if (req_valid) begin
        load = 1'b1;
        clr  = 1'b1;
        nxt  = S_SETUP;
      end
      S_SETUP: begin
        if (setup_last) nxt = S_ACCESS;
        else            inc = 1'b1;
      end
      S_ACCESS, S_EXTEND: begin
        if (busy) begin
          clr = 1'b1;
          nxt = S_WAIT;
        end else begin
          cap = !h_wr;
          nxt = S_DONE;
        end
      end
      S_WAIT: begin
        if (!busy) nxt = S_EXTEND;
        else if (cnt == LAST_TO) begin
          tmo = 1'b1;
          nxt = S_IDLE;
        end else inc = 1'b1;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      err_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      err_pulse <= tmo;
    end
  end
endmodule

// File: rtl/busy_port_seq.sv
module busy_port_seq
  import bpa_pkg::*;
#(
  parameter int AW          = 11,
  parameter int DW          = 16,
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 16,
  parameter bit SLAVE_MODE  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic            rsp_is_write,
  output logic [DW-1:0]   rsp_rdata,
  output logic            err_timeout,
  output logic            mem_ce,
  output logic            mem_oe,
  output logic [DW/8-1:0] mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_busy
);
  localparam int BW   = DW / 8;
  localparam int MAXC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bpa_state_e    state;
  logic          load, cap, clr, inc;
  logic [CW-1:0] cnt;
  logic [BW-1:0] h_be;
  logic          h_wr;
  logic          strobe;

  bpa_ctrl #(
    .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .SLAVE_MODE(SLAVE_MODE), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .h_wr(h_wr),
    .busy(mem_busy), .cnt(cnt), .state(state), .load(load), .cap(cap),
    .clr(clr), .inc(inc), .err_pulse(err_timeout)
  );

  bpa_cycle_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cnt(cnt)
  );

  bpa_req_hold #(.AW(AW), .DW(DW), .BW(BW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_be(req_be), .in_wr(req_write),
    .cap(cap), .mem_rdata(mem_rdata),
    .h_addr(mem_addr), .h_wdata(mem_wdata), .h_be(h_be), .h_wr(h_wr),
    .h_rdata(rsp_rdata)
  );

  assign strobe       = (state == S_ACCESS) || (state == S_WAIT) || (state == S_EXTEND);
  assign mem_ce       = strobe || (state == S_SETUP);
  assign mem_oe       = strobe && !h_wr;
  assign mem_we       = (strobe && h_wr) ? h_be : '0;
  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_DONE);
  assign rsp_is_write = h_wr;
endmodule

// File: rtl/busy_port_seq_chk.sv
module busy_port_seq_chk #(
  parameter int AW         = 11,
  parameter int DW         = 16,
  parameter int SETTLE_CYC = 2,
  parameter bit SLAVE_MODE = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            err_timeout,
  input logic            mem_ce,
  input logic            mem_oe,
  input logic [DW/8-1:0] mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_busy
);
  logic        stb;
  int unsigned ce_run;
  int unsigned need;

  assign stb  = mem_oe || (|mem_we);
  assign need = (SLAVE_MODE && (|mem_we)) ? SETTLE_CYC : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ce_run <= 0;
    else if (mem_ce) ce_run <= ce_run + 1;
    else             ce_run <= 0;
  end

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |-> !req_ready);

  a_r2_settle_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> (mem_ce && ce_run >= need));

  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_oe && (|mem_we)));

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && $past(stb)) |-> ($stable(mem_addr) && $stable(mem_wdata) &&
                             $stable(mem_we) && $stable(mem_oe)));

  a_r4_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mem_busy) |=> (stb || err_timeout));

  a_r5_done_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(stb) && !$past(mem_busy)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (req_ready && !mem_ce && !rsp_valid));
endmodule

bind busy_port_seq busy_port_seq_chk #(
  .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC), .SLAVE_MODE(SLAVE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .err_timeout(err_timeout), .mem_ce(mem_ce), .mem_oe(mem_oe),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_busy(mem_busy)
);

// File: tb/test_busy_port_seq.sv
`timescale 1ns/1ps
module test_busy_port_seq;
  localparam int AW = 11, DW = 16, BW = 2, SETTLE = 2, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_busy = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_is_write, err_timeout, mem_ce, mem_oe;
  logic [BW-1:0] mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rsp_rdata;

  int checks = 0, errors = 0;
  bit running = 1'b0, finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] fmem(input logic [AW-1:0] a);
    return 16'(a * 37) ^ 16'hC3A5;
  endfunction

  assign mem_rdata = mem_busy ? 16'hDEAD : fmem(mem_addr);

  busy_port_seq #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO),
                  .SLAVE_MODE(1'b1)) i_busy_port_seq (.*);

  // reference model: 0 idle, 1 address-only, 2 strobe, 3 waiting, 5 response
  int ph = 0, n = 0, w = 0;
  bit m_ext = 0, m_err = 0, mwr = 0;
  logic [AW-1:0] ma = '0;
  logic [DW-1:0] md = '0, mrd = '0;
  logic [BW-1:0] mbe = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_err = 0; m_ext = 0;
    end else begin
      m_err = 0;
      case (ph)
        0: if (req_valid) begin
             ma = req_addr; md = req_wdata; mbe = req_be; mwr = req_write;
             n = 0; m_ext = 0; ph = 1;
           end
        1: begin n++; if (n >= (mwr ? SETTLE : 1)) ph = 2; end
        2: if (mem_busy) begin ph = 3; w = 0; end
           else begin if (!mwr) mrd = fmem(ma); ph = 5; end
        3: if (!mem_busy) begin ph = 2; m_ext = 1; end
           else begin w++; if (w >= TMO) begin ph = 0; m_err = 1; end end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      automatic bit stb = (ph == 2) || (ph == 3);
      automatic string stag = (ph == 3) ? "R4 strobe hold" : (m_ext ? "R5 extend" : "R3 strobe");
      chk("R1 req_ready", req_ready, ph == 0);
      chk("R2 mem_ce", mem_ce, (ph >= 1) && (ph <= 3));
      chk({stag, " oe"}, mem_oe, stb && !mwr);
      chk({stag, " we"}, mem_we, (stb && mwr) ? mbe : 2'b00);
      if (mem_ce) begin
        chk("R3 mem_addr", mem_addr, ma);
        if (mwr) chk("R3 mem_wdata", mem_wdata, md);
      end
      chk("R6 rsp_valid", rsp_valid, ph == 5);
      if (ph == 5) begin
        chk("R6 rsp_is_write", rsp_is_write, mwr);
        if (!mwr) chk("R6 rsp_rdata", rsp_rdata, mrd);
      end
      chk("R7 err_timeout", err_timeout, m_err);
    end
  end

  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [BW-1:0] be, input logic [63:0] bp);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    for (int i = 0; i < 64; i++) begin
      mem_busy = bp[i];
      @(negedge clk);
      if (rsp_valid || err_timeout) break;
    end
    mem_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset req_ready", req_ready, 1);
    chk("R8 reset rsp_valid", rsp_valid, 0);
    chk("R8 reset err_timeout", err_timeout, 0);
    chk("R8 reset mem_ce", mem_ce, 0);
    chk("R8 reset mem_oe", mem_oe, 0);
    chk("R8 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    run(0, 11'h123, 16'h0,    2'b00, 64'h0);        // R3 plain read
    run(1, 11'h045, 16'hBEEF, 2'b11, 64'h0);        // R2 settle on write
    run(1, 11'h7FF, 16'h1234, 2'b01, 64'b11100);    // R4 busy in access
    run(0, 11'h200, 16'h0,    2'b00, 64'b010110);   // R5 busy back in extend
    run(0, 11'h300, 16'h0,    2'b00, {64{1'b1}});   // R7 timeout
    run(0, 11'h301, 16'h0,    2'b00, 64'h0);        // R1 recovery
    run(0, 11'h0AA, 16'h0,    2'b00, 64'h1FFFE);    // R7 one short of limit
    run(1, 11'h155, 16'hA5A5, 2'b10, 64'b11);       // R2 busy in settle ignored
    run(1, 11'h156, 16'h5A5A, 2'b11, 64'b0100);     // R5 one-cycle busy on write
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule